// File: doc/BRIEF.md
# Multiphase Switching Sequence Timer and Gate Encoder

This block plays out one modulation period of a multiphase multilevel converter built from two cascaded cells per phase. For every phase it holds a lower and an upper cell state, each a pair of three-valued digits (one digit per cell). It also holds the order in which phases step from lower to upper, and the dwell fractions of the intermediate states. Over a fixed switching period it walks through P+1 states. The first state has every phase at its lower level, the last has every phase at its upper level, and each boundary moves exactly one phase. Each phase's two digits are turned into four gate trigger bits.

An upstream calculator writes a complete parameter set at any time into a shadow bank. The set becomes active only when the period counter wraps. The block raises a one-cycle period-start pulse that the calculator can use to begin the next computation. With the default 50 MHz clock, a 10000-cycle period gives a 5 kHz switching rate. Dwell fractions are unsigned Q0.16. Each is multiplied by the period length and truncated, and the results are accumulated into step boundaries. The final state has no dwell input of its own: it fills whatever remains of the period.

Top module: `ssq_gate_sequencer`

## Requirements
- R1: After reset, until a written parameter set takes effect, `gate` is all zero and `step` equals P.
- R2: `period_start` is a one-cycle pulse repeating every PERIOD cycles. In the cycle it is high, `gate` and `step` show elapsed count 0 of the period.
- R3: With d_i = floor(dwell_i * PERIOD / 65536) and boundary b_i = min(PERIOD, d_0 + ... + d_i) for i = 0..P-1, `step` at elapsed count t equals the number of boundaries with b_i <= t. The final state (step P) lasts to the end of the period, so the period length never depends on rounding.
- R4: At step 0 every phase applies its lower state. At step s, the phases named by order entries 0..s-1 apply their upper state and all others their lower state. Order entry m (field [m*OW +: OW] of `prm_order`) names the phase that moves on entering step m+1.
- R5: A dwell that truncates to zero cycles is skipped: no cycle shows that step, and `step` jumps past it.
- R6: Per phase j, bits [4j+3:4j+2] of `gate` encode cell 1 from state bits [4j+3:4j+2], and bits [4j+1:4j] encode cell 2 from state bits [4j+1:4j]. The first trigger of each pair is the upper bit. Digit 0 gives pair 01, digit 1 gives 00, and digit 2 gives 10.
- R7: State digit value 3 is treated as digit 1 (pair 00). No pair ever shows 11.
- R8: A write with `prm_wr` does not change the current period. It takes effect at the next period start, and among several writes within one period the last one is used.
- R9: Within a period `step` never decreases, and `gate` changes only in cycles where `step` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prm_wr | input | 1 | Write strobe for the shadow parameter bank |
| prm_lo | input | 4*P | Lower cell state per phase, two 2-bit digits (cell 1 high) |
| prm_hi | input | 4*P | Upper cell state per phase, same layout |
| prm_order | input | P*OW | Phase switching order, entry m moves on entering step m+1 |
| prm_dwell | input | P*DW | Q0.16 dwell fractions of steps 0..P-1 |
| gate | output | 4*P | Gate trigger bits, four per phase |
| step | output | SW | Current step index 0..P |
| period_start | output | 1 | One-cycle pulse at the first cycle of each period |

## Verification
The hardest situations to reach from the ports are the ones that straddle the period wrap. A write landing mid-period must not disturb the state sequence already being played. A second write in the same period must replace the first before the swap. The bench synchronises to the period-start pulse and injects two writes at fixed offsets inside a checked period. It compares every cycle against the old parameter set, then checks the following period against the last write. Zero-length and saturating dwell sets are added as directed cases among random ones. They exercise skipped steps and a final state that receives no cycles.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  // Map one three-valued cell digit to its trigger pair {first, second}.
  function automatic logic [1:0] trig_pair(input logic [1:0] digit);
    case (digit)
      2'd0:    return 2'b01;
      2'd2:    return 2'b10;
      default: return 2'b00; // digit 1, and the unused code 3
    endcase
  endfunction

endpackage

// File: rtl/ssq_period_counter.sv
module ssq_period_counter #(
  parameter  int unsigned PERIOD = 10000,
  localparam int unsigned CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          wrap
);

  logic [CW-1:0] cnt_d;

  assign wrap = (cnt == CW'(PERIOD - 1));

  always_comb begin
    cnt_d = wrap ? '0 : cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/ssq_param_bank.sv
module ssq_param_bank #(
  parameter  int unsigned P      = 5,
  parameter  int unsigned PERIOD = 10000,
  parameter  int unsigned DW     = 16,
  localparam int unsigned OW     = (P > 1) ? $clog2(P) : 1,
  localparam int unsigned BW     = $clog2(PERIOD) + 1,
  localparam int unsigned AW     = BW + $clog2(P) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  swap,
  input  logic [4*P-1:0]        in_lo,
  input  logic [4*P-1:0]        in_hi,
  input  logic [P*OW-1:0]       in_order,
  input  logic [P*DW-1:0]       in_dwell,
  output logic [4*P-1:0]        act_lo,
  output logic [4*P-1:0]        act_hi,
  output logic [P*OW-1:0]       act_order,
  output logic [P-1:0][BW-1:0]  act_bnd
);

  // Neutral cell state: both digits at 1 (zero output, all triggers low).
  localparam logic [4*P-1:0] NEUTRAL = {P{4'b0101}};

  logic [4*P-1:0]       sh_lo, sh_hi;
  logic [P*OW-1:0]      sh_order;
  logic [P*DW-1:0]      sh_dwell;
  logic [P-1:0][BW-1:0] bnd_d;
  logic [DW+BW-1:0]     prod;
  logic [AW-1:0]        acc;

  // Shadow bank, written by the calculator at any time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_lo    <= NEUTRAL;
      sh_hi    <= NEUTRAL;
      sh_order <= '0;
      sh_dwell <= '0;
    end else if (wr_en) begin
      sh_lo    <= in_lo;
      sh_hi    <= in_hi;
      sh_order <= in_order;
      sh_dwell <= in_dwell;
    end
  end

  // Scale each dwell by the period length and accumulate the boundaries,
  // saturating at the period so later steps collapse to zero length.
  always_comb begin
    acc  = '0;
    prod = '0;
    for (int i = 0; i < P; i++) begin
      prod = (DW+BW)'(sh_dwell[i*DW +: DW]) * (DW+BW)'(PERIOD);
      acc  = acc + AW'(prod >> DW);
      bnd_d[i] = (acc > AW'(PERIOD)) ? BW'(PERIOD) : acc[BW-1:0];
    end
  end

  // Active bank, replaced only on the period wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_lo    <= NEUTRAL;
      act_hi    <= NEUTRAL;
      act_order <= '0;
      act_bnd   <= '0;
    end else if (swap) begin
      act_lo    <= sh_lo;
      act_hi    <= sh_hi;
      act_order <= sh_order;
      act_bnd   <= bnd_d;
    end
  end

endmodule

// File: rtl/ssq_state_select.sv
module ssq_state_select #(
  parameter  int unsigned P      = 5,
  parameter  int unsigned PERIOD = 10000,
  localparam int unsigned OW     = (P > 1) ? $clog2(P) : 1,
  localparam int unsigned CW     = $clog2(PERIOD),
  localparam int unsigned BW     = CW + 1,
  localparam int unsigned SW     = $clog2(P + 2)
) (
  input  logic [CW-1:0]         cnt,
  input  logic [4*P-1:0]        act_lo,
  input  logic [4*P-1:0]        act_hi,
  input  logic [P*OW-1:0]       act_order,
  input  logic [P-1:0][BW-1:0]  act_bnd,
  output logic [SW-1:0]         step,
  output logic [4*P-1:0]        state
);

  logic [P-1:0] up_sel;

  // Step index: number of boundaries already reached this period.
  always_comb begin
    step = '0;
    for (int i = 0; i < P; i++) begin
      if ({1'b0, cnt} >= act_bnd[i]) step = step + SW'(1);
    end
  end

  // A phase is at its upper state once its order slot has been passed.
  always_comb begin
    up_sel = '0;
    for (int j = 0; j < P; j++) begin
      for (int m = 0; m < P; m++) begin
        if ((SW'(m) < step) && (act_order[m*OW +: OW] == OW'(j))) up_sel[j] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int j = 0; j < P; j++) begin
      state[j*4 +: 4] = up_sel[j] ? act_hi[j*4 +: 4] : act_lo[j*4 +: 4];
    end
  end

endmodule

// File: rtl/ssq_gate_encoder.sv
module ssq_gate_encoder #(
  parameter int unsigned P = 5
) (
  input  logic [4*P-1:0] state,
  output logic [4*P-1:0] gate
);

  import ssq_pkg::*;

  for (genvar j = 0; j < P; j++) begin : g_phase
    assign gate[j*4+2 +: 2] = trig_pair(state[j*4+2 +: 2]); // cell 1
    assign gate[j*4   +: 2] = trig_pair(state[j*4   +: 2]); // cell 2
  end

endmodule

// File: rtl/ssq_gate_sequencer.sv
module ssq_gate_sequencer #(
  parameter  int unsigned P      = 5,
  parameter  int unsigned PERIOD = 10000,
  parameter  int unsigned DW     = 16,
  localparam int unsigned OW     = (P > 1) ? $clog2(P) : 1,
  localparam int unsigned SW     = $clog2(P + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prm_wr,
  input  logic [4*P-1:0]    prm_lo,
  input  logic [4*P-1:0]    prm_hi,
  input  logic [P*OW-1:0]   prm_order,
  input  logic [P*DW-1:0]   prm_dwell,
  output logic [4*P-1:0]    gate,
  output logic [SW-1:0]     step,
  output logic              period_start
);

  localparam int unsigned CW = $clog2(PERIOD);
  localparam int unsigned BW = CW + 1;

  logic [CW-1:0]        cnt;
  logic                 wrap;
  logic [4*P-1:0]       act_lo, act_hi;
  logic [P*OW-1:0]      act_order;
  logic [P-1:0][BW-1:0] act_bnd;
  logic [SW-1:0]        step_d;
  logic [4*P-1:0]       state_d;
  logic [4*P-1:0]       gate_d;
  logic                 pstart_d;

  ssq_period_counter #(.PERIOD(PERIOD)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt  (cnt),
    .wrap (wrap)
  );

  ssq_param_bank #(.P(P), .PERIOD(PERIOD), .DW(DW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (prm_wr),
    .swap     (wrap),
    .in_lo    (prm_lo),
    .in_hi    (prm_hi),
    .in_order (prm_order),
    .in_dwell (prm_dwell),
    .act_lo   (act_lo),
    .act_hi   (act_hi),
    .act_order(act_order),
    .act_bnd  (act_bnd)
  );

  ssq_state_select #(.P(P), .PERIOD(PERIOD)) u_sel (
    .cnt      (cnt),
    .act_lo   (act_lo),
    .act_hi   (act_hi),
    .act_order(act_order),
    .act_bnd  (act_bnd),
    .step     (step_d),
    .state    (state_d)
  );

  ssq_gate_encoder #(.P(P)) u_enc (
    .state(state_d),
    .gate (gate_d)
  );

  always_comb begin
    pstart_d = (cnt == '0);
  end

  // Output register: all outputs aligned to the same elapsed count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate         <= '0;
      step         <= '0;
      period_start <= 1'b0;
    end else begin
      gate         <= gate_d;
      step         <= step_d;
      period_start <= pstart_d;
    end
  end

endmodule

// File: rtl/ssq_gate_sequencer_chk.sv
module ssq_gate_sequencer_chk #(
  parameter  int unsigned P      = 5,
  parameter  int unsigned PERIOD = 10000,
  localparam int unsigned SW     = $clog2(P + 2),
  localparam int unsigned GW     = $clog2(PERIOD) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            period_start,
  input logic [SW-1:0]   step,
  input logic [4*P-1:0]  gate
);

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      gap  <= period_start ? '0 : gap + GW'(1);
      seen <= seen | period_start;
    end
  end

  // R2
  period_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && seen) |-> (gap == GW'(PERIOD - 1)));

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

  // R9
  step_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> (step >= $past(step)));

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_start && (step == $past(step))) |-> $stable(gate));

  // R3
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step <= SW'(P));

  for (genvar i = 0; i < 2*P; i++) begin : g_pair
    // R7
    pair_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate[2*i +: 2] != 2'b11);
  end

endmodule

bind ssq_gate_sequencer ssq_gate_sequencer_chk #(.P(P), .PERIOD(PERIOD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .period_start(period_start),
  .step        (step),
  .gate        (gate)
);

// File: tb/ssq_gate_sequencer_tb.sv
`timescale 1ns/1ps
module ssq_gate_sequencer_tb;

  localparam int P      = 5;
  localparam int PERIOD = 400;
  localparam int DW     = 16;
  localparam int OW     = 3;
  localparam int SW     = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            prm_wr = 1'b0;
  logic [4*P-1:0]  prm_lo = '0;
  logic [4*P-1:0]  prm_hi = '0;
  logic [P*OW-1:0] prm_order = '0;
  logic [P*DW-1:0] prm_dwell = '0;
  logic [4*P-1:0]  gate;
  logic [SW-1:0]   step;
  logic            period_start;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  bit at_start = 0;

  // model parameters of the period being checked
  logic [4*P-1:0]  e_lo, e_hi;
  logic [P*OW-1:0] e_ord;
  logic [P*DW-1:0] e_dw;
  // mid-period writes
  logic [4*P-1:0]  a_lo, a_hi, b_lo, b_hi;
  logic [P*OW-1:0] a_ord, b_ord;
  logic [P*DW-1:0] a_dw, b_dw;
  logic [4*P-1:0]  first_gate, last_gate;

  always #4 clk = ~clk;

  ssq_gate_sequencer #(.P(P), .PERIOD(PERIOD), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .prm_wr(prm_wr), .prm_lo(prm_lo), .prm_hi(prm_hi),
    .prm_order(prm_order), .prm_dwell(prm_dwell), .gate(gate), .step(step),
    .period_start(period_start)
  );

  function automatic logic [1:0] pair_of(input logic [1:0] d);
    if (d == 2'd0) return 2'b01;
    if (d == 2'd2) return 2'b10;
    return 2'b00;
  endfunction

  function automatic int exp_step(input logic [P*DW-1:0] dw, input int t);
    longint acc = 0;
    longint b;
    int s = 0;
    for (int i = 0; i < P; i++) begin
      acc = acc + ((longint'(dw[i*DW +: DW]) * PERIOD) >> 16);
      b = (acc > PERIOD) ? PERIOD : acc;
      if (b <= t) s++;
    end
    return s;
  endfunction

  function automatic logic [4*P-1:0] exp_gate(input logic [4*P-1:0] lo, input logic [4*P-1:0] hi,
                                              input logic [P*OW-1:0] ord, input int s);
    logic [4*P-1:0] g;
    logic [3:0] st;
    bit up;
    for (int j = 0; j < P; j++) begin
      up = 0;
      for (int m = 0; m < s; m++) if (int'(ord[m*OW +: OW]) == j) up = 1;
      st = up ? hi[j*4 +: 4] : lo[j*4 +: 4];
      g[j*4+2 +: 2] = pair_of(st[3:2]);
      g[j*4   +: 2] = pair_of(st[1:0]);
    end
    return g;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sync_start();
    if (at_start) begin
      at_start = 0;
      return;
    end
    do @(negedge clk); while (!period_start);
  endtask

  task automatic drive(input logic [4*P-1:0] lo, input logic [4*P-1:0] hi,
                       input logic [P*OW-1:0] ord, input logic [P*DW-1:0] dw);
    prm_lo = lo; prm_hi = hi; prm_order = ord; prm_dwell = dw;
  endtask

  // Check one full period against e_*; mid=1 injects write A then write B.
  task automatic run_period(input string tag, input bit mid);
    int gbad = 0, sbad = 0, pbad = 0, es;
    logic [4*P-1:0] eg;
    sync_start();
    for (int t = 0; t < PERIOD; t++) begin
      if (t > 0) @(negedge clk);
      es = exp_step(e_dw, t);
      eg = exp_gate(e_lo, e_hi, e_ord, es);
      if (int'(step) != es) begin
        if (sbad == 0) $display("  step t=%0d act=%0d exp=%0d", t, step, es);
        sbad++;
      end
      if (gate !== eg) begin
        if (gbad == 0) $display("  gate t=%0d act=%0h exp=%0h", t, gate, eg);
        gbad++;
      end
      if ((t == 0) != (period_start == 1'b1)) pbad++;
      if (t == 0) first_gate = gate;
      if (t == PERIOD-1) last_gate = gate;
      if (mid && t == PERIOD/2)     begin drive(a_lo, a_hi, a_ord, a_dw); prm_wr = 1'b1; end
      if (mid && t == PERIOD/2 + 1) prm_wr = 1'b0;
      if (mid && t == PERIOD/2 + 4) begin drive(b_lo, b_hi, b_ord, b_dw); prm_wr = 1'b1; end
      if (mid && t == PERIOD/2 + 5) prm_wr = 1'b0;
    end
    @(negedge clk);
    if (!period_start) pbad++;
    at_start = 1;
    check(gbad == 0, tag, "gate mismatch cycles", gbad, 0);
    check(sbad == 0, tag, "step mismatch cycles", sbad, 0);
    check(pbad == 0, "R2", "period_start misplaced", pbad, 0);
  endtask

  task automatic load_and_run(input logic [4*P-1:0] lo, input logic [4*P-1:0] hi,
                              input logic [P*OW-1:0] ord, input logic [P*DW-1:0] dw,
                              input string tag);
    sync_start();
    repeat (3) @(negedge clk);
    drive(lo, hi, ord, dw);
    prm_wr = 1'b1;
    @(negedge clk);
    prm_wr = 1'b0;
    e_lo = lo; e_hi = hi; e_ord = ord; e_dw = dw;
    run_period(tag, 1'b0);
  endtask

  function automatic logic [4*P-1:0] rnd_state();
    logic [4*P-1:0] s;
    for (int j = 0; j < P; j++) s[j*4 +: 4] = {2'($urandom % 3), 2'($urandom % 3)};
    return s;
  endfunction

  function automatic logic [P*OW-1:0] rnd_order();
    int a[P];
    int k, tmp;
    logic [P*OW-1:0] o;
    for (int i = 0; i < P; i++) a[i] = i;
    for (int i = P-1; i > 0; i--) begin
      k = int'($urandom % (i + 1));
      tmp = a[i]; a[i] = a[k]; a[k] = tmp;
    end
    for (int i = 0; i < P; i++) o[i*OW +: OW] = OW'(a[i]);
    return o;
  endfunction

  function automatic logic [P*DW-1:0] rnd_dwell();
    logic [P*DW-1:0] d;
    for (int i = 0; i < P; i++) d[i*DW +: DW] = DW'($urandom % (65536 / (P + 1)));
    return d;
  endfunction

  logic [P*OW-1:0] ord_seq;
  logic [P*DW-1:0] dw_eq;

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < P; i++) begin
      ord_seq[i*OW +: OW] = OW'(i);
      dw_eq[i*DW +: DW]   = DW'(65536 / (P + 1));
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: neutral output, all boundaries at zero
    check(gate == '0, "R1", "gate after reset", gate, 0);
    check(int'(step) == P, "R1", "step after reset", step, P);

    // R6: lower digits {0,2} -> nibble 0110, upper digits {1,1} -> 0000
    load_and_run({P{4'b0010}}, {P{4'b0101}}, ord_seq, dw_eq, "R6");
    check(first_gate == {P{4'b0110}}, "R6", "first-state gate", first_gate, {P{4'b0110}});
    check(last_gate == '0, "R6", "last-state gate", last_gate, 0);

    // R4: lower all digit 2 (10,10), upper all digit 0 (01,01)
    load_and_run({P{4'b1010}}, {P{4'b0000}}, rnd_order(), dw_eq, "R4");
    check(first_gate == {P{4'b1010}}, "R4", "step 0 all lower", first_gate, {P{4'b1010}});
    check(last_gate == {P{4'b0101}}, "R4", "final step all upper", last_gate, {P{4'b0101}});

    // R7: code 3 acts as digit 1
    load_and_run({P{4'b1111}}, {P{4'b1100}}, ord_seq, dw_eq, "R7");
    check(first_gate == '0, "R7", "digit 3 pair", first_gate, 0);
    check(last_gate == {P{4'b0001}}, "R7", "mixed 3/0 pair", last_gate, {P{4'b0001}});

    // R5: zero-length dwells at steps 0 and 2
    begin
      logic [P*DW-1:0] dz;
      dz = dw_eq;
      dz[0*DW +: DW] = '0;
      dz[2*DW +: DW] = DW'(100); // truncates to 0 cycles at PERIOD=400
      load_and_run(rnd_state(), rnd_state(), rnd_order(), dz, "R5");
      check(int'(first_gate) == int'(exp_gate(e_lo, e_hi, e_ord, 1)), "R5",
            "step 0 skipped", first_gate, exp_gate(e_lo, e_hi, e_ord, 1));
    end

    // R3: boundaries saturate, final state gets no cycles
    load_and_run(rnd_state(), rnd_state(), rnd_order(), {P{16'd30000}}, "R3");
    check(last_gate == exp_gate(e_lo, e_hi, e_ord, 2), "R3", "saturated last gate",
          last_gate, exp_gate(e_lo, e_hi, e_ord, 2));

    // R3 R4 R6: random patterns
    for (int n = 0; n < 6; n++) load_and_run(rnd_state(), rnd_state(), rnd_order(), rnd_dwell(), "R3");

    // R8: two writes mid-period; current stays, next uses the last write
    a_lo = rnd_state(); a_hi = rnd_state(); a_ord = rnd_order(); a_dw = rnd_dwell();
    b_lo = rnd_state(); b_hi = rnd_state(); b_ord = rnd_order(); b_dw = rnd_dwell();
    load_and_run(rnd_state(), rnd_state(), rnd_order(), rnd_dwell(), "R8");
    run_period("R8", 1'b1);
    e_lo = b_lo; e_hi = b_hi; e_ord = b_ord; e_dw = b_dw;
    run_period("R8", 1'b0);
    // R8: no write -> parameters persist
    run_period("R8", 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

endmodule